// File: doc/BRIEF.md
# Hit List Frame Formatter

The block takes the hits of one bunch crossing and packs them into a fixed 80-bit output word. Hits arrive as one flag per detector channel plus a 6-bit arrival-time value (ART) per channel. The word is handed on as two 40-bit halves, one for each serial link. Each crossing is marked by a one-cycle `frame_valid` strobe. The packed word and an overflow flag are registered on that strobe and hold until the next one.

A mode input selects one of two layouts.

- **Occupancy layout.** A 32-bit occupancy map is followed by eight 6-bit ART slots. The slots are filled in ascending channel order.
- **Record layout.** Up to seven 11-bit records are packed from bit 0 upward. Each record holds a channel number and an ART value. The top three bits are spare.

In both layouts, unused slots and spare bits are zero. Hits beyond a layout's slot count are dropped from the slots, and the overflow flag is raised for that crossing. The slots are filled by a chain of priority-select stages. Each stage takes the lowest remaining hit channel.

Top module: `hitfmt_top`

## Requirements
- R1: `dout_valid` is high in exactly the cycle after a cycle with `frame_valid` high, and low otherwise.
- R2: Between strobes, `dout_lo`, `dout_hi` and `overflow` keep their values, whatever the other inputs do.
- R3: A crossing with no hit flags set gives an all-zero 80-bit word with `overflow` low, in both modes.
- R4: With `fmt_mode`=0 (occupancy layout), word bits [31:0] equal `hit_flags`, with bit i standing for channel i.
- R5: With `fmt_mode`=0, ART slot k sits at word bits [32+6k+5 : 32+6k], for k = 0..7. It carries the ART of the k-th lowest flagged channel. Slots past the hit count are zero.
- R6: With `fmt_mode`=0 and more than 8 hits, the ARTs of the lowest 8 channels fill the slots and `overflow` is high. With 8 or fewer hits, `overflow` is low.
- R7: With `fmt_mode`=1 (record layout), record k sits at word bits [11k+10 : 11k], for k = 0..6, as {channel[4:0], ART[5:0]}. Records hold the flagged channels in ascending order. Unused records are zero.
- R8: With `fmt_mode`=1 and more than 7 hits, only the lowest 7 channels are recorded and `overflow` is high. With 7 or fewer hits, `overflow` is low.
- R9: With `fmt_mode`=1, word bits [79:77] are zero.
- R10: `dout_lo` carries word bits [39:0] and `dout_hi` carries word bits [79:40].
- R11: While `rst` is high, and in the cycle after it, the block outputs zeros, with `dout_valid` and `overflow` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a crossing's hits |
| fmt_mode | input | 1 | 0 = occupancy layout, 1 = record layout |
| hit_flags | input | 32 | Hit flag per channel, bit i = channel i |
| hit_art | input | 192 | ART per channel, channel i at bits [6i+5:6i] |
| dout_lo | output | 40 | Word bits [39:0] |
| dout_hi | output | 40 | Word bits [79:40] |
| dout_valid | output | 1 | New word present this cycle |
| overflow | output | 1 | More hits than slots in the last crossing |

## Verification
Slot truncation and ascending-order selection act in the same cycle whenever a crossing carries more hits than its layout has slots. The bench provokes this with exactly 7, 8 and 9 hits in both modes, including hits on channel 31. It also sends random crossings whose hit counts cluster around the two slot limits. Each word is judged field by field against a bench model, which walks the channels upward, fills slots until they run out and then sets the expected overflow. This shows that the dropped hits are always the highest channels and that the flag agrees with the count.

// File: rtl/hitfmt_pkg.sv
package hitfmt_pkg;
  typedef enum logic {
    FMT_OCCUPANCY = 1'b0,
    FMT_RECORD    = 1'b1
  } fmt_mode_e;
endpackage

// File: rtl/hitfmt_picker.sv
// Cascade of priority-select stages: stage k isolates the lowest hit
// channel left after stages 0..k-1 and encodes its index.
module hitfmt_picker #(
  parameter int N_CH  = 32,
  parameter int PICKS = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  flags,
  output logic [PICKS-1:0] pick_vld,
  output logic [IDX_W-1:0] pick_idx [PICKS]
);
  logic [N_CH-1:0] remain [PICKS+1];
  assign remain[0] = flags;

  for (genvar k = 0; k < PICKS; k++) begin : g_stage
    logic [N_CH-1:0] lowest;
    assign lowest        = remain[k] & (~remain[k] + 1'b1);
    assign remain[k+1]   = remain[k] & ~lowest;
    assign pick_vld[k]   = |remain[k];

    always_comb begin
      pick_idx[k] = '0;
      for (int i = 0; i < N_CH; i++)
        if (lowest[i]) pick_idx[k] = IDX_W'(i);
    end
  end
endmodule

// File: rtl/hitfmt_count.sv
module hitfmt_count #(
  parameter int N_CH = 32,
  localparam int CNT_W = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0]  flags,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N_CH; i++)
      count = count + CNT_W'(flags[i]);
  end
endmodule

// File: rtl/hitfmt_packer.sv
module hitfmt_packer
  import hitfmt_pkg::*;
#(
  parameter int N_CH    = 32,
  parameter int ART_W   = 6,
  parameter int FRAME_W = 80,
  parameter int PICKS   = 8,
  localparam int IDX_W     = $clog2(N_CH),
  localparam int REC_W     = IDX_W + ART_W,
  localparam int OCC_SLOTS = (FRAME_W - N_CH) / ART_W,
  localparam int REC_SLOTS = FRAME_W / REC_W
) (
  input  fmt_mode_e            mode,
  input  logic [N_CH-1:0]      flags,
  input  logic [N_CH*ART_W-1:0] art_bus,
  input  logic [PICKS-1:0]     pick_vld,
  input  logic [IDX_W-1:0]     pick_idx [PICKS],
  output logic [FRAME_W-1:0]   frame
);
  logic [ART_W-1:0]   art_of [PICKS];
  logic [FRAME_W-1:0] occ_frame;
  logic [FRAME_W-1:0] rec_frame;

  for (genvar k = 0; k < PICKS; k++) begin : g_art
    assign art_of[k] = pick_vld[k] ? art_bus[pick_idx[k]*ART_W +: ART_W] : '0;
  end

  always_comb begin
    occ_frame = '0;
    occ_frame[N_CH-1:0] = flags;
    for (int k = 0; k < OCC_SLOTS; k++)
      occ_frame[N_CH + k*ART_W +: ART_W] = art_of[k];
  end

  always_comb begin
    rec_frame = '0;
    for (int k = 0; k < REC_SLOTS; k++)
      if (pick_vld[k])
        rec_frame[k*REC_W +: REC_W] = {pick_idx[k], art_of[k]};
  end

  assign frame = (mode == FMT_RECORD) ? rec_frame : occ_frame;
endmodule

// File: rtl/hitfmt_top.sv
module hitfmt_top
  import hitfmt_pkg::*;
#(
  parameter int N_CH    = 32,
  parameter int ART_W   = 6,
  parameter int FRAME_W = 80,
  localparam int HALF_W    = FRAME_W / 2,
  localparam int IDX_W     = $clog2(N_CH),
  localparam int CNT_W     = $clog2(N_CH + 1),
  localparam int REC_W     = IDX_W + ART_W,
  localparam int OCC_SLOTS = (FRAME_W - N_CH) / ART_W,
  localparam int REC_SLOTS = FRAME_W / REC_W,
  localparam int PICKS     = (OCC_SLOTS > REC_SLOTS) ? OCC_SLOTS : REC_SLOTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_valid,
  input  logic                  fmt_mode,
  input  logic [N_CH-1:0]       hit_flags,
  input  logic [N_CH*ART_W-1:0] hit_art,
  output logic [HALF_W-1:0]     dout_lo,
  output logic [HALF_W-1:0]     dout_hi,
  output logic                  dout_valid,
  output logic                  overflow
);
  fmt_mode_e          mode;
  logic [PICKS-1:0]   pick_vld;
  logic [IDX_W-1:0]   pick_idx [PICKS];
  logic [CNT_W-1:0]   hit_cnt;
  logic [FRAME_W-1:0] frame_d;
  logic [FRAME_W-1:0] frame_q;
  logic               ovf_d;

  assign mode = fmt_mode_e'(fmt_mode);

  hitfmt_picker #(.N_CH(N_CH), .PICKS(PICKS)) picker_i (
    .flags(hit_flags), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  hitfmt_count #(.N_CH(N_CH)) count_i (
    .flags(hit_flags), .count(hit_cnt)
  );

  hitfmt_packer #(.N_CH(N_CH), .ART_W(ART_W), .FRAME_W(FRAME_W), .PICKS(PICKS)) packer_i (
    .mode(mode), .flags(hit_flags), .art_bus(hit_art),
    .pick_vld(pick_vld), .pick_idx(pick_idx), .frame(frame_d)
  );

  assign ovf_d = (mode == FMT_RECORD) ? (hit_cnt > CNT_W'(REC_SLOTS))
                                      : (hit_cnt > CNT_W'(OCC_SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= '0;
      overflow   <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= frame_valid;
      if (frame_valid) begin
        frame_q  <= frame_d;
        overflow <= ovf_d;
      end
    end
  end

  assign dout_lo = frame_q[HALF_W-1:0];
  assign dout_hi = frame_q[FRAME_W-1:HALF_W];

  // R1: output strobe follows the input strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> dout_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> !dout_valid);
  // R2: word holds between strobes
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> ($stable(dout_lo) && $stable(dout_hi) && $stable(overflow)));
  // R3: empty crossing yields an all-zero word
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && hit_flags == '0) |=> (dout_lo == '0 && dout_hi == '0 && !overflow));
  // R4: occupancy map lands in the low bits
  a_r4_occ_map: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !fmt_mode) |=> (dout_lo[N_CH-1:0] == $past(hit_flags)));
  // R8: few enough hits never raise overflow in record layout
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && fmt_mode && $countones(hit_flags) <= REC_SLOTS) |=> !overflow);
  // R6: same for the occupancy layout
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !fmt_mode && $countones(hit_flags) <= OCC_SLOTS) |=> !overflow);
  // R9: spare bits are zero in record layout
  a_r9_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && fmt_mode) |=> (dout_hi[HALF_W-1:REC_SLOTS*REC_W-HALF_W] == '0));
  // R11: reset clears the outputs
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (dout_lo == '0 && dout_hi == '0 && !dout_valid && !overflow));
endmodule

// File: tb/hitfmt_top_tb_top.sv
`timescale 1ns/1ps
module hitfmt_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         frame_valid;
  logic         fmt_mode;
  logic [31:0]  hit_flags;
  logic [191:0] hit_art;
  logic [39:0]  dout_lo;
  logic [39:0]  dout_hi;
  logic         dout_valid;
  logic         overflow;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  hitfmt_top dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .fmt_mode(fmt_mode),
    .hit_flags(hit_flags), .hit_art(hit_art), .dout_lo(dout_lo),
    .dout_hi(dout_hi), .dout_valid(dout_valid), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Bench model: walk channels upward, fill slots until exhausted.
  function automatic logic [80:0] model(input logic [31:0] fl, input logic [191:0] art, input logic md);
    logic [79:0] w = '0;
    int n = 0;
    int slots = md ? 7 : 8;
    if (!md) w[31:0] = fl;
    for (int ch = 0; ch < 32; ch++) begin
      if (fl[ch]) begin
        if (n < slots) begin
          if (md) w[11*n +: 11] = {ch[4:0], art[6*ch +: 6]};
          else    w[32 + 6*n +: 6] = art[6*ch +: 6];
        end
        n++;
      end
    end
    return {(n > slots), w};
  endfunction

  function automatic logic [31:0] rand_flags(input int target);
    logic [31:0] f = '0;
    int c = 0;
    while (c < target) begin
      int b = $urandom_range(0, 31);
      if (!f[b]) begin f[b] = 1'b1; c++; end
    end
    return f;
  endfunction

  function automatic logic [191:0] rand_art();
    logic [191:0] a;
    for (int i = 0; i < 6; i++) a[32*i +: 32] = $urandom;
    return a;
  endfunction

  task automatic send(input logic [31:0] fl, input logic [191:0] art, input logic md);
    logic [80:0] e;
    logic [79:0] got;
    e = model(fl, art, md);
    @(negedge clk);
    hit_flags = fl; hit_art = art; fmt_mode = md; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    got = {dout_hi, dout_lo};
    chk(dout_valid == 1'b1, "R1 valid after strobe", 80'(dout_valid), 80'd1);
    chk(dout_lo == e[39:0], "R10 low half", 80'(dout_lo), 80'(e[39:0]));
    chk(dout_hi == e[79:40], "R10 high half", 80'(dout_hi), 80'(e[79:40]));
    if (fl == '0)
      chk(got == '0 && !overflow, "R3 empty word", got, 80'd0);
    if (!md) begin
      chk(got[31:0] == fl, "R4 occupancy map", 80'(got[31:0]), 80'(fl));
      chk(got[79:32] == e[79:32], "R5 ART slots", 80'(got[79:32]), 80'(e[79:32]));
      chk(overflow == e[80], "R6 overflow", 80'(overflow), 80'(e[80]));
    end else begin
      chk(got[76:0] == e[76:0], "R7 records", 80'(got[76:0]), 80'(e[76:0]));
      chk(overflow == e[80], "R8 overflow", 80'(overflow), 80'(e[80]));
      chk(got[79:77] == 3'b000, "R9 spare bits", 80'(got[79:77]), 80'd0);
    end
    // Idle cycle with disturbed inputs: word must hold.
    hit_flags = $urandom; hit_art = rand_art(); fmt_mode = ~md;
    @(negedge clk);
    chk(!dout_valid, "R1 no valid without strobe", 80'(dout_valid), 80'd0);
    chk({dout_hi, dout_lo} == got && overflow == e[80], "R2 hold", {dout_hi, dout_lo}, got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; frame_valid = 1'b0; fmt_mode = 1'b0;
    hit_flags = '1; hit_art = '1;
    repeat (3) @(negedge clk);
    chk({dout_hi, dout_lo} == '0 && !dout_valid && !overflow, "R11 reset state",
        {dout_hi, dout_lo}, 80'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({dout_hi, dout_lo} == '0 && !dout_valid, "R11 after reset", {dout_hi, dout_lo}, 80'd0);

    // Directed corners in both layouts: 0, 7, 8, 9, all hits, top channel.
    for (int md = 0; md < 2; md++) begin
      send(32'h0, rand_art(), md[0]);
      send(32'h0000_007F, rand_art(), md[0]);
      send(32'h0000_00FF, rand_art(), md[0]);
      send(32'h0000_01FF, rand_art(), md[0]);
      send(32'h8000_0000, rand_art(), md[0]);
      send(32'hFFFF_FFFF, rand_art(), md[0]);
      send(32'h8000_007F, rand_art(), md[0]);
      send(32'hC000_003F, rand_art(), md[0]);
      send(32'hC000_007F, rand_art(), md[0]);
    end

    // Random crossings with counts clustered around the slot limits.
    for (int t = 0; t < 400; t++) begin
      int target;
      if ($urandom_range(0, 3) == 0) target = $urandom_range(0, 32);
      else                           target = $urandom_range(5, 10);
      send(rand_flags(target), rand_art(), 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule